// File: doc/BRIEF.md
# Streaming Natural-Log Coprocessor Wrapper

This block attaches a fixed-latency natural-logarithm engine to a host processor through two one-way, point-to-point word links. Each link is a synchronous FIFO 32 data bits wide. A 33rd flag bit travels beside the data and marks control words or frame boundaries. The host pushes operands into the inbound link and takes results out of the outbound link with non-blocking put and get operations. There are no registers mapped into an address space: every exchange is a word passed through a link.

A four-state sequencer in the wrapper moves through idle, load, busy and push. In idle it waits until the inbound link is not empty. In load it pops the head word. For a data word it pulses start on the engine. In busy it waits for the engine's done or error strobe. In push it waits until the outbound link has room, then writes exactly one result word. If a popped word has its flag bit set, the wrapper skips the engine and returns the word unchanged, going straight from load to push. When the engine reports an error, the wrapper returns a quiet NaN with the flag bit set, so the host can tell that the operand failed.

The engine treats the operand as an IEEE single-precision value with the sign in bit 31, the biased exponent in bits 30:23 and the fraction in bits 22:0. It forms the piecewise-linear base-2 logarithm and scales it by ln 2. The answer is a two's-complement fixed-point number with 23 fraction bits.

Top module: `lncop_wrap`

## Requirements
- R1: After reset the inbound-full flag `h2c_full` and the outbound-data flag `c2h_valid` are both 0.
- R2: A data word (flag bit 0) with sign 0 and biased exponent e in 1..254 returns the low 32 bits of floor((((e-127)*2^23 + fraction) * 1488522236) / 2^31), with the flag bit 0.
- R3: A data word with sign bit 1, or with biased exponent 0 or 255, returns 0x7FC00000 with the flag bit 1.
- R4: A word pushed with the flag bit 1 is returned with the same 32 data bits and the flag bit 1, and does not start the engine.
- R5: Every accepted inbound word yields exactly one outbound word, in arrival order. No word is lost or duplicated when the host pushes and pops at random moments.
- R6: When the wrapper is idle and the outbound link is empty, a data word's result becomes visible on `c2h_valid` exactly LATENCY+4 rising edges after the edge that accepted the push.
- R7: Under the same conditions, an echoed flag word becomes visible exactly 3 rising edges after the edge that accepted the push.
- R8: While the outbound link is full, the wrapper stays in push and holds its result stable. Once 2*DEPTH+1 words are outstanding, `h2c_full` is 1. Draining afterwards returns every word correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h2c_push | input | 1 | Host writes a word into the inbound link |
| h2c_data | input | 32 | Inbound data word |
| h2c_ctrl | input | 1 | Inbound flag bit (control word / frame mark) |
| h2c_full | output | 1 | Inbound link cannot accept a word |
| c2h_pop | input | 1 | Host removes the head word of the outbound link |
| c2h_data | output | 32 | Outbound head data word |
| c2h_ctrl | output | 1 | Outbound head flag bit |
| c2h_valid | output | 1 | Outbound link holds at least one word |

## Verification
Outputs are sampled on falling edges, and all timing is counted from the rising edge that accepts a push. Starting from idle with an empty outbound link, a computed result is due LATENCY+4 rising edges after that edge and an echoed flag word is due 3 rising edges after it. The directed checks count falling edges until `c2h_valid` rises and compare the count with these exact figures. The random stream and the back-pressure run do not depend on timing: they match each outbound word, in order, against a queue of expected values that bench functions compute when each word is pushed.

// File: rtl/lncop_pkg.sv
package lncop_pkg;
    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int EXP_BIAS = 127;
    localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;
    // ln(2) in Q1.31, rounded
    localparam logic [WORD_W-1:0] LN2_Q31   = 32'd1488522236;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_BUSY,
        ST_PUSH
    } wrap_state_t;

    typedef struct packed {
        logic              ctrl;
        logic [WORD_W-1:0] data;
    } link_word_t;
endpackage

// File: rtl/link_fifo.sv
module link_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign dout  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop && !empty) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_ptr[AW-1:0]] <= din;
        end
    end
endmodule

// File: rtl/ln_engine.sv
module ln_engine
    import lncop_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] operand,
    output logic              done,
    output logic              error,
    output logic [WORD_W-1:0] result
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [WORD_W-1:0] op_q;
    logic [CW-1:0]     cnt_q;
    logic              busy_q;
    logic              fin_q;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              bad;
    logic signed [9:0]          ue;
    logic signed [WORD_W-1:0]   ue_ext;
    logic signed [WORD_W-1:0]   lin;
    logic signed [2*WORD_W-1:0] prod;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                op_q   <= operand;
                cnt_q  <= CW'(LATENCY);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        exp_f  = op_q[WORD_W-2 -: EXP_W];
        frac_f = op_q[FRAC_W-1:0];
        bad    = op_q[WORD_W-1] || (exp_f == '0) || (exp_f == '1);
        ue     = $signed({2'b00, exp_f}) - 10'sd127;
        ue_ext = {{(WORD_W-10){ue[9]}}, ue};
        lin    = (ue_ext <<< FRAC_W) | $signed({{(WORD_W-FRAC_W){1'b0}}, frac_f});
        prod   = $signed({{WORD_W{lin[WORD_W-1]}}, lin}) * $signed({{WORD_W{1'b0}}, LN2_Q31});
        result = prod[2*WORD_W-2 -: WORD_W];
    end

    assign done  = fin_q && !bad;
    assign error = fin_q && bad;
endmodule

// File: rtl/lncop_wrap.sv
module lncop_wrap
    import lncop_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LATENCY = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h2c_push,
    input  logic [31:0] h2c_data,
    input  logic        h2c_ctrl,
    output logic        h2c_full,
    input  logic        c2h_pop,
    output logic [31:0] c2h_data,
    output logic        c2h_ctrl,
    output logic        c2h_valid
);
    localparam int LW = WORD_W + 1;

    wrap_state_t       state_q;
    wrap_state_t       state_d;
    link_word_t        in_head;
    link_word_t        out_word;
    link_word_t        out_head;
    logic              in_empty;
    logic              in_pop;
    logic              out_full;
    logic              out_empty;
    logic              out_push;
    logic              core_start;
    logic              core_done;
    logic              core_err;
    logic [WORD_W-1:0] core_res;
    logic [WORD_W-1:0] res_q;
    logic              res_ctrl_q;

    link_fifo #(.WIDTH(LW), .DEPTH(DEPTH)) u_in_link (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (h2c_push),
        .din   ({h2c_ctrl, h2c_data}),
        .pop   (in_pop),
        .dout  (in_head),
        .full  (h2c_full),
        .empty (in_empty)
    );

    ln_engine #(.LATENCY(LATENCY)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (core_start),
        .operand (in_head.data),
        .done    (core_done),
        .error   (core_err),
        .result  (core_res)
    );

    assign out_word = '{ctrl: res_ctrl_q, data: res_q};

    link_fifo #(.WIDTH(LW), .DEPTH(DEPTH)) u_out_link (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (out_push),
        .din   (out_word),
        .pop   (c2h_pop),
        .dout  (out_head),
        .full  (out_full),
        .empty (out_empty)
    );

    assign c2h_data  = out_head.data;
    assign c2h_ctrl  = out_head.ctrl;
    assign c2h_valid = !out_empty;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!in_empty) state_d = ST_LOAD;
            ST_LOAD: state_d = in_head.ctrl ? ST_PUSH : ST_BUSY;
            ST_BUSY: if (core_done || core_err) state_d = ST_PUSH;
            ST_PUSH: if (!out_full) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        in_pop     = 1'b0;
        core_start = 1'b0;
        out_push   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                in_pop     = 1'b1;
                core_start = !in_head.ctrl;
            end
            ST_BUSY: ;
            ST_PUSH: out_push = !out_full;
            default: ;
        endcase
    end

    // result holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_ctrl_q <= 1'b0;
        end else if (state_q == ST_LOAD && in_head.ctrl) begin
            res_q      <= in_head.data;
            res_ctrl_q <= 1'b1;
        end else if (state_q == ST_BUSY && core_err) begin
            res_q      <= QNAN_WORD;
            res_ctrl_q <= 1'b1;
        end else if (state_q == ST_BUSY && core_done) begin
            res_q      <= core_res;
            res_ctrl_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lncop_wrap_chk.sv
module lncop_wrap_chk
    import lncop_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input wrap_state_t       st,
    input logic              in_pop,
    input logic              in_empty,
    input logic              in_ctrl,
    input logic              out_push,
    input logic              out_full,
    input logic              core_start,
    input logic              core_err,
    input logic [WORD_W-1:0] res_data,
    input logic              res_ctrl
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (in_pop && !out_push) begin
            pend_q <= 1'b1;
        end else if (out_push && !in_pop) begin
            pend_q <= 1'b0;
        end
    end

    AST_POP_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n) in_pop |-> !in_empty); // R5
    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n) out_push |-> !out_full); // R5
    AST_ONE_POP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n) in_pop |-> !pend_q); // R5
    AST_PUSH_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n) out_push |-> pend_q); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PUSH && out_full) |=> (st == ST_PUSH && $stable(res_data) && $stable(res_ctrl))); // R8
    AST_ERR_GIVES_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && core_err) |=> (res_data == QNAN_WORD && res_ctrl)); // R3
    AST_ECHO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && in_ctrl) |-> !core_start); // R4
endmodule

bind lncop_wrap lncop_wrap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (state_q),
    .in_pop     (in_pop),
    .in_empty   (in_empty),
    .in_ctrl    (in_head.ctrl),
    .out_push   (out_push),
    .out_full   (out_full),
    .core_start (core_start),
    .core_err   (core_err),
    .res_data   (res_q),
    .res_ctrl   (res_ctrl_q)
);

// File: tb/lncop_wrap_bench.sv
module lncop_wrap_bench;
    localparam int DEPTH   = 16;
    localparam int LATENCY = 8;
    localparam int NRAND   = 300;
    localparam int NBP     = 2*DEPTH + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h2c_push = 1'b0;
    logic [31:0] h2c_data = '0;
    logic        h2c_ctrl = 1'b0;
    logic        h2c_full;
    logic        c2h_pop = 1'b0;
    logic [31:0] c2h_data;
    logic        c2h_ctrl;
    logic        c2h_valid;

    int checks = 0;
    int errors = 0;
    logic [32:0] expq [0:511];
    logic [32:0] sentw [0:511];

    always #2 clk = ~clk;

    lncop_wrap #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_lncop_wrap (
        .clk(clk), .rst_n(rst_n),
        .h2c_push(h2c_push), .h2c_data(h2c_data), .h2c_ctrl(h2c_ctrl), .h2c_full(h2c_full),
        .c2h_pop(c2h_pop), .c2h_data(c2h_data), .c2h_ctrl(c2h_ctrl), .c2h_valid(c2h_valid)
    );

    function automatic logic [32:0] model(input logic [32:0] w);
        logic [7:0]  e;
        longint      lin;
        longint      prod;
        if (w[32]) return w;
        e = w[30:23];
        if (w[31] || e == 8'd0 || e == 8'd255) return {1'b1, 32'h7FC0_0000};
        lin  = (longint'(e) - 127) * 8388608 + longint'(w[22:0]);
        prod = lin * 64'sd1488522236;
        prod = prod >>> 31;
        return {1'b0, prod[31:0]};
    endfunction

    function automatic logic [32:0] rand_word();
        int unsigned k = $urandom % 16;
        if (k == 0) return {1'b1, 32'($urandom)};
        if (k == 1) return {1'b0, 32'($urandom) | 32'h8000_0000};
        if (k == 2) return {1'b0, 1'b0, 8'd0, 23'($urandom)};
        if (k == 3) return {1'b0, 1'b0, 8'd255, 23'($urandom)};
        return {1'b0, 1'b0, 8'(1 + ($urandom % 254)), 23'($urandom)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push_one(input logic [32:0] w);
        @(negedge clk);
        h2c_push = 1'b1; h2c_ctrl = w[32]; h2c_data = w[31:0];
        @(negedge clk);
        h2c_push = 1'b0;
    endtask

    task automatic pop_check(input logic [32:0] expv, input string req);
        check(c2h_valid && {c2h_ctrl, c2h_data} == expv, req, {c2h_ctrl, c2h_data}, expv);
        c2h_pop = 1'b1;
        @(negedge clk);
        c2h_pop = 1'b0;
    endtask

    task automatic single(input logic [32:0] w, input int due, input string req_lat, input string req_val);
        int n = 0;
        push_one(w);
        while (!c2h_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == due, req_lat, 33'(n), 33'(due));
        pop_check(model(w), req_val);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20151101));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!h2c_full && !c2h_valid, "R1", {31'd0, h2c_full, c2h_valid}, 33'd0);

        // R2 and R6: computed values with exact latency
        single({1'b0, 32'h3F80_0000}, LATENCY + 4, "R6", "R2");
        single({1'b0, 32'h4000_0000}, LATENCY + 4, "R6", "R2");
        single({1'b0, 32'h0080_0000}, LATENCY + 4, "R6", "R2");
        single({1'b0, 32'h7F7F_FFFF}, LATENCY + 4, "R6", "R2");
        // R4 and R7: echo of a flag word
        single({1'b1, 32'hDEAD_BEEF}, 3, "R7", "R4");
        single({1'b1, 32'h3F80_0000}, 3, "R7", "R4");
        // R3: error operands
        single({1'b0, 32'hBF80_0000}, LATENCY + 4, "R6", "R3");
        single({1'b0, 32'h0000_0000}, LATENCY + 4, "R6", "R3");
        single({1'b0, 32'h0000_0001}, LATENCY + 4, "R6", "R3");
        single({1'b0, 32'h7F80_0000}, LATENCY + 4, "R6", "R3");
        single({1'b0, 32'h7FC0_0000}, LATENCY + 4, "R6", "R3");

        // R5: random stream with random push and pop timing
        begin
            int snd = 0;
            int rcv = 0;
            int guard = 0;
            while (rcv < NRAND && guard < 60000) begin
                @(negedge clk);
                guard++;
                h2c_push = 1'b0;
                c2h_pop  = 1'b0;
                if (c2h_valid && ($urandom % 3 != 0)) begin
                    check({c2h_ctrl, c2h_data} == expq[rcv], "R5", {c2h_ctrl, c2h_data}, expq[rcv]);
                    rcv++;
                    c2h_pop = 1'b1;
                end
                if (snd < NRAND && !h2c_full && ($urandom % 2 == 0)) begin
                    logic [32:0] w;
                    w = rand_word();
                    expq[snd] = model(w);
                    h2c_push = 1'b1; h2c_ctrl = w[32]; h2c_data = w[31:0];
                    snd++;
                end
            end
            @(negedge clk);
            h2c_push = 1'b0;
            c2h_pop  = 1'b0;
            check(rcv == NRAND, "R5", 33'(rcv), 33'(NRAND));
        end

        // R8: back-pressure, outbound never read while filling
        begin
            int snd = 0;
            int guard = 0;
            while (snd < NBP && guard < 2000) begin
                @(negedge clk);
                guard++;
                h2c_push = 1'b0;
                if (!h2c_full) begin
                    logic [32:0] w;
                    w = (snd % 5 == 4) ? {1'b1, 32'($urandom)} : {1'b0, 1'b0, 8'(100 + snd), 23'($urandom)};
                    sentw[snd] = w;
                    h2c_push = 1'b1; h2c_ctrl = w[32]; h2c_data = w[31:0];
                    snd++;
                end
            end
            @(negedge clk);
            h2c_push = 1'b0;
            repeat (100) @(negedge clk);
            check(h2c_full && c2h_valid, "R8", {31'd0, h2c_full, c2h_valid}, 33'd3);
            for (int i = 0; i < NBP; i++) begin
                pop_check(model(sentw[i]), "R8");
                if (i < DEPTH + 1) begin
                    repeat (LATENCY + 4) @(negedge clk);
                end
            end
            repeat (5) @(negedge clk);
            check(!c2h_valid && !h2c_full, "R8", {31'd0, h2c_full, c2h_valid}, 33'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule